// File: doc/BRIEF.md
# Bus-Master Disk DMA Engine

This block is the data mover of one disk-controller channel. Software programs three registers through a small register port: a command byte, a status byte and a 32-bit pointer to a table of transfer descriptors. Once the start bit is set and the attached device signals that a transfer is pending, the engine walks the table. For each descriptor it moves the stated number of bytes between system memory and the device data stream, one 32-bit beat at a time. The command byte sets the direction.

Each descriptor is two little-endian 32-bit words. The first is the buffer address. The second holds the byte count in bits 15:1 and an end-of-table flag in bit 31. The run ends when any of these happens: the flagged descriptor is finished, the device reports that it is done, or 512 descriptors have been processed. At the end the engine drops its active bit and raises its interrupt flag. A stop written by software ends the run quietly at the next beat boundary. A two-channel controller places a second instance of this block 8 bytes above the first.

Memory uses one valid/ready request channel with a same-cycle response. A request is accepted in the cycle where `mem_valid` and `mem_ready` are both high. Once raised, `mem_valid` stays high and address, write flag, write data and lane enables stay stable until that cycle. Read data is taken from `mem_rdata` in the accepting cycle. The device streams follow the same rule: a beat moves when valid and ready are both high, and a raised `dout_valid` holds with stable data until `dout_ready`. The engine raises `din_ready` only when it can take a beat, and it may lower `din_ready` at any time. The device may hold `din_valid` for as long as it likes, and memory or the device may stall for any number of cycles.

Top module: `busmaster_dma`

## Requirements
- R1: The command byte is at register offset 0. Bit 0 is start and bit 3 is direction (1 = device stream to memory, 0 = memory to device stream). Only these two bits are stored; every other bit reads back as zero.
- R2: The status byte is at offset 2. Bit 0 is active, bit 1 is error and bit 2 is interrupt. A write stores bits 6 and 5 as given, leaves bit 0 unchanged, and clears bit 1 or bit 2 only where the written value has a 1.
- R3: The descriptor-table pointer is at offset 4 and is 32 bits wide. A write to it forces bits 1:0 to zero.
- R4: Writing start=1 sets the active bit. A walk begins only while active is set and `dev_pending` is high, so with no pending transfer no memory request is made. Writing start=0 clears the active bit.
- R5: A descriptor is two words: the buffer address at the table pointer, then the size word at pointer+4. After each descriptor that does not end the run, the descriptor pointer advances by 8. Within a descriptor, the buffer address advances by the number of bytes each beat moves.
- R6: The byte count is size-word bits 15:1 times two, and a count of zero means 65536 bytes. Every beat moves 4 bytes, except that a remainder of 2 bytes moves in a final beat whose lane enables (`mem_be` or `dout_keep`) are 0011. A full beat uses 1111.
- R7: With direction 1, each accepted `din` beat is written to memory at the current buffer address. With direction 0, each memory word read from the buffer address is presented on `dout`.
- R8: After finishing a descriptor whose bit 31 is set, the engine clears active and sets the interrupt bit, and `irq` goes high.
- R9: When `dev_done` is high at a beat boundary, the run ends at once: no further beat is taken, active is cleared and the interrupt bit is set.
- R10: A run processes at most 512 descriptors. After the 512th one without an end flag, it ends as in R8.
- R11: After start=0 is written during a run, the engine finishes at most the beat in progress and then makes no further memory or stream transfer. The interrupt bit is left unchanged.
- R12: Once `mem_valid` or `dout_valid` is high, it stays high with stable request fields or data until it is accepted.
- R13: If a run completes in the same cycle as a status write that clears the interrupt bit, the interrupt bit ends up set.
- R14: After reset, all three registers read zero, `irq` is low and no memory request or stream beat is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register byte offset (0, 2, 4) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq | output | 1 | Interrupt status bit |
| dev_pending | input | 1 | Device has a transfer waiting |
| dev_done | input | 1 | Device reports its transfer finished |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Request byte address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Write lane enables |
| mem_rdata | input | 32 | Read data, valid in the accepting cycle |
| din_valid | input | 1 | Device-to-memory beat valid |
| din_ready | output | 1 | Engine takes a device beat |
| din_data | input | 32 | Device-to-memory beat data |
| dout_valid | output | 1 | Memory-to-device beat valid |
| dout_ready | input | 1 | Device takes the beat |
| dout_data | output | 32 | Memory-to-device beat data |
| dout_keep | output | 4 | Valid byte lanes of the beat |

## Verification
Run completion and a software write to the status byte can land on the same clock edge. Both act on the interrupt bit: completion sets it and the write clears it. The bench parks a device-to-memory run at a beat boundary by withholding `din_valid`. It then raises `dev_done` in exactly the cycle that carries a status write of 0x04. After that edge the interrupt bit must be set, active must be clear, and no memory write may have happened.

// File: rtl/bmd_pkg.sv
package bmd_pkg;
  // register byte offsets, decoded by the register port
  localparam logic [2:0] OFS_CMD  = 3'd0;
  localparam logic [2:0] OFS_STAT = 3'd2;
  localparam logic [2:0] OFS_PTR  = 3'd4;

  localparam int CMD_START_BIT = 0;
  localparam int CMD_DIR_BIT   = 3;
  localparam int ST_ACT_BIT    = 0;
  localparam int ST_ERR_BIT    = 1;
  localparam int ST_IRQ_BIT    = 2;

  localparam int DESC_BYTES = 8;

  typedef enum logic [2:0] {
    W_IDLE,
    W_FETCH_ADDR,
    W_FETCH_SIZE,
    W_DECIDE,
    W_WRITE,
    W_READ,
    W_PUSH
  } walk_state_e;
endpackage

// File: rtl/bmd_regs.sv
module bmd_regs
  import bmd_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              run_done,
  output logic              cmd_dir,
  output logic              st_active,
  output logic              st_irq,
  output logic [ADDR_W-1:0] tbl_ptr
);
  logic       cmd_start_q;
  logic       st_err_q;
  logic [1:0] st_spare_q;
  logic       wr_cmd, wr_stat, wr_ptr;

  assign wr_cmd  = reg_we && (reg_addr == OFS_CMD);
  assign wr_stat = reg_we && (reg_addr == OFS_STAT);
  assign wr_ptr  = reg_we && (reg_addr == OFS_PTR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_start_q <= 1'b0;
      cmd_dir     <= 1'b0;
      st_active   <= 1'b0;
      st_err_q    <= 1'b0;
      st_irq      <= 1'b0;
      st_spare_q  <= 2'b00;
      tbl_ptr     <= '0;
    end else begin
      // software intent on the start bit outranks run completion
      if (wr_cmd) begin
        cmd_start_q <= reg_wdata[CMD_START_BIT];
        cmd_dir     <= reg_wdata[CMD_DIR_BIT];
        st_active   <= reg_wdata[CMD_START_BIT];
      end else if (run_done) begin
        st_active <= 1'b0;
      end
      // completion outranks a clearing write so no interrupt is lost
      if (run_done) begin
        st_irq <= 1'b1;
      end else if (wr_stat && reg_wdata[ST_IRQ_BIT]) begin
        st_irq <= 1'b0;
      end
      if (wr_stat) begin
        st_err_q   <= st_err_q & ~reg_wdata[ST_ERR_BIT];
        st_spare_q <= reg_wdata[6:5];
      end
      if (wr_ptr) begin
        tbl_ptr <= {reg_wdata[ADDR_W-1:2], 2'b00};
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_CMD: begin
        reg_rdata[CMD_START_BIT] = cmd_start_q;
        reg_rdata[CMD_DIR_BIT]   = cmd_dir;
      end
      OFS_STAT: begin
        reg_rdata[ST_ACT_BIT] = st_active;
        reg_rdata[ST_ERR_BIT] = st_err_q;
        reg_rdata[ST_IRQ_BIT] = st_irq;
        reg_rdata[6:5]        = st_spare_q;
      end
      OFS_PTR:  reg_rdata = 32'(tbl_ptr);
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/bmd_desc_decode.sv
module bmd_desc_decode #(
  parameter int LEN_W = 16
) (
  input  logic [31:0]  size_word,
  output logic [LEN_W:0] byte_len,
  output logic         last
);
  logic [LEN_W-2:0] half_cnt;

  assign half_cnt = size_word[LEN_W-1:1];
  // a zero count stands for the full 2**LEN_W bytes
  assign byte_len = (half_cnt == '0) ? {1'b1, {LEN_W{1'b0}}}
                                     : {1'b0, half_cnt, 1'b0};
  assign last     = size_word[31];
endmodule

// File: rtl/bmd_walker.sv
module bmd_walker
  import bmd_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int LEN_W    = 16,
  parameter int MAX_DESC = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              dir,
  input  logic [ADDR_W-1:0] tbl_ptr,
  input  logic              dev_pending,
  input  logic              dev_done,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  output logic [3:0]        mem_be,
  input  logic [31:0]       mem_rdata,
  input  logic              din_valid,
  output logic              din_ready,
  input  logic [31:0]       din_data,
  output logic              dout_valid,
  input  logic              dout_ready,
  output logic [31:0]       dout_data,
  output logic [3:0]        dout_keep,
  output logic              run_done
);
  localparam int CNT_W = (MAX_DESC > 1) ? $clog2(MAX_DESC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MAX_DESC - 1);

  walk_state_e       state_q, state_d;
  logic [ADDR_W-1:0] desc_ptr_q, buf_q;
  logic [LEN_W:0]    rem_q;
  logic              last_q, dir_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [31:0]       hold_q;

  logic [LEN_W:0]    dec_len;
  logic              dec_last;
  logic              half_beat;
  logic [3:0]        lanes;
  logic [ADDR_W-1:0] step_a;
  logic [LEN_W:0]    step_l;
  logic              next_desc, take_din, start_walk;

  bmd_desc_decode #(.LEN_W(LEN_W)) u_decode (
    .size_word (mem_rdata),
    .byte_len  (dec_len),
    .last      (dec_last)
  );

  assign half_beat = (rem_q[LEN_W:2] == '0);
  assign lanes     = half_beat ? 4'b0011 : 4'b1111;
  assign step_a    = half_beat ? ADDR_W'(2) : ADDR_W'(4);
  assign step_l    = half_beat ? (LEN_W+1)'(2) : (LEN_W+1)'(4);

  always_comb begin
    state_d    = state_q;
    mem_valid  = 1'b0;
    mem_we     = 1'b0;
    mem_addr   = buf_q;
    mem_wdata  = hold_q;
    mem_be     = 4'b0000;
    din_ready  = 1'b0;
    dout_valid = 1'b0;
    dout_data  = hold_q;
    dout_keep  = 4'b0000;
    run_done   = 1'b0;
    next_desc  = 1'b0;
    take_din   = 1'b0;
    start_walk = 1'b0;
    case (state_q)
      W_IDLE: begin
        if (active && dev_pending) begin
          start_walk = 1'b1;
          state_d    = W_FETCH_ADDR;
        end
      end
      W_FETCH_ADDR: begin
        mem_valid = 1'b1;
        mem_addr  = desc_ptr_q;
        if (mem_ready) state_d = W_FETCH_SIZE;
      end
      W_FETCH_SIZE: begin
        mem_valid = 1'b1;
        mem_addr  = desc_ptr_q + ADDR_W'(4);
        if (mem_ready) state_d = W_DECIDE;
      end
      W_DECIDE: begin
        // beat boundary: stop, device completion and descriptor end
        if (!active) begin
          state_d = W_IDLE;
        end else if (dev_done) begin
          run_done = 1'b1;
          state_d  = W_IDLE;
        end else if (rem_q == '0) begin
          if (last_q || (cnt_q == CNT_LAST)) begin
            run_done = 1'b1;
            state_d  = W_IDLE;
          end else begin
            next_desc = 1'b1;
            state_d   = W_FETCH_ADDR;
          end
        end else if (dir_q) begin
          din_ready = 1'b1;
          if (din_valid) begin
            take_din = 1'b1;
            state_d  = W_WRITE;
          end
        end else begin
          state_d = W_READ;
        end
      end
      W_WRITE: begin
        mem_valid = 1'b1;
        mem_we    = 1'b1;
        mem_be    = lanes;
        if (mem_ready) state_d = W_DECIDE;
      end
      W_READ: begin
        mem_valid = 1'b1;
        if (mem_ready) state_d = W_PUSH;
      end
      W_PUSH: begin
        dout_valid = 1'b1;
        dout_keep  = lanes;
        if (dout_ready) state_d = W_DECIDE;
      end
      default: state_d = W_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= W_IDLE;
      desc_ptr_q <= '0;
      buf_q      <= '0;
      rem_q      <= '0;
      last_q     <= 1'b0;
      dir_q      <= 1'b0;
      cnt_q      <= '0;
      hold_q     <= '0;
    end else begin
      state_q <= state_d;
      if (start_walk) begin
        desc_ptr_q <= tbl_ptr;
        cnt_q      <= '0;
        dir_q      <= dir;
      end
      if (state_q == W_FETCH_ADDR && mem_ready) begin
        buf_q <= mem_rdata[ADDR_W-1:0];
      end
      if (state_q == W_FETCH_SIZE && mem_ready) begin
        rem_q  <= dec_len;
        last_q <= dec_last;
      end
      if (next_desc) begin
        desc_ptr_q <= desc_ptr_q + ADDR_W'(DESC_BYTES);
        cnt_q      <= cnt_q + CNT_W'(1);
      end
      if (take_din) begin
        hold_q <= din_data;
      end
      if (state_q == W_READ && mem_ready) begin
        hold_q <= mem_rdata;
      end
      if ((state_q == W_WRITE && mem_ready) ||
          (state_q == W_PUSH && dout_ready)) begin
        buf_q <= buf_q + step_a;
        rem_q <= rem_q - step_l;
      end
    end
  end
endmodule

// File: rtl/busmaster_dma.sv
module busmaster_dma #(
  parameter int ADDR_W   = 32,
  parameter int LEN_W    = 16,
  parameter int MAX_DESC = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq,
  input  logic              dev_pending,
  input  logic              dev_done,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  output logic [3:0]        mem_be,
  input  logic [31:0]       mem_rdata,
  input  logic              din_valid,
  output logic              din_ready,
  input  logic [31:0]       din_data,
  output logic              dout_valid,
  input  logic              dout_ready,
  output logic [31:0]       dout_data,
  output logic [3:0]        dout_keep
);
  logic              cmd_dir, st_active, st_irq, run_done;
  logic [ADDR_W-1:0] tbl_ptr;

  bmd_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .run_done  (run_done),
    .cmd_dir   (cmd_dir),
    .st_active (st_active),
    .st_irq    (st_irq),
    .tbl_ptr   (tbl_ptr)
  );

  bmd_walker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_DESC(MAX_DESC)) u_walker (
    .clk         (clk),
    .rst_n       (rst_n),
    .active      (st_active),
    .dir         (cmd_dir),
    .tbl_ptr     (tbl_ptr),
    .dev_pending (dev_pending),
    .dev_done    (dev_done),
    .mem_valid   (mem_valid),
    .mem_ready   (mem_ready),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_be      (mem_be),
    .mem_rdata   (mem_rdata),
    .din_valid   (din_valid),
    .din_ready   (din_ready),
    .din_data    (din_data),
    .dout_valid  (dout_valid),
    .dout_ready  (dout_ready),
    .dout_data   (dout_data),
    .dout_keep   (dout_keep),
    .run_done    (run_done)
  );

  assign irq = st_irq;
endmodule

// File: rtl/bmd_chk.sv
module bmd_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [2:0]        reg_addr,
  input logic [31:0]       reg_rdata,
  input logic              irq,
  input logic              st_active,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_wdata,
  input logic [3:0]        mem_be,
  input logic              dout_valid,
  input logic              dout_ready,
  input logic [31:0]       dout_data,
  input logic [3:0]        dout_keep
);
  // R12
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we)
                                 && $stable(mem_wdata) && $stable(mem_be));

  // R12
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid && !dout_ready |=> dout_valid && $stable(dout_data) && $stable(dout_keep));

  // R3
  ptr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 3'd4) |-> (reg_rdata[1:0] == 2'b00));

  // R1
  cmd_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 3'd0) |-> ((reg_rdata & 32'hFFFF_FFF6) == 32'h0));

  // R8
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) && !($past(reg_we) && ($past(reg_addr) == 3'd0)) |-> !st_active);

  // R6
  lane_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_we |-> (mem_be == 4'hF) || (mem_be == 4'h3));

  // R6
  keep_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid |-> (dout_keep == 4'hF) || (dout_keep == 4'h3));
endmodule

bind busmaster_dma bmd_chk #(.ADDR_W(ADDR_W)) u_bmd_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_we     (reg_we),
  .reg_addr   (reg_addr),
  .reg_rdata  (reg_rdata),
  .irq        (irq),
  .st_active  (st_active),
  .mem_valid  (mem_valid),
  .mem_ready  (mem_ready),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .mem_be     (mem_be),
  .dout_valid (dout_valid),
  .dout_ready (dout_ready),
  .dout_data  (dout_data),
  .dout_keep  (dout_keep)
);

// File: tb/test_busmaster_dma.sv
`timescale 1ns/1ps
module test_busmaster_dma;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  logic        dev_pending = 1'b0;
  logic        dev_done = 1'b0;
  logic        mem_valid, mem_ready, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;
  logic        din_valid, din_ready;
  logic [31:0] din_data;
  logic        dout_valid, dout_ready;
  logic [31:0] dout_data;
  logic [3:0]  dout_keep;

  logic din_en = 1'b0, dout_en = 1'b0, stall_en = 1'b0, cnt_clr = 1'b0;
  logic [31:0] mem [256];
  logic [7:0]  stall_cnt = '0;
  logic [15:0] din_idx = '0;
  int          wr_cnt = 0, dout_cnt = 0, req_cyc = 0, hs_viol = 0;
  logic [31:0] dout_last = '0;
  logic [3:0]  keep_last = '0;
  logic        prev_mem_wait = 1'b0, prev_dout_wait = 1'b0;
  logic [31:0] prev_mem_addr = '0, prev_dout_data = '0;
  int          checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  busmaster_dma i_busmaster_dma (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .dev_pending(dev_pending), .dev_done(dev_done),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
    .mem_rdata(mem_rdata), .din_valid(din_valid), .din_ready(din_ready),
    .din_data(din_data), .dout_valid(dout_valid), .dout_ready(dout_ready),
    .dout_data(dout_data), .dout_keep(dout_keep)
  );

  // memory and device models
  assign mem_ready  = stall_en ? (stall_cnt[1:0] != 2'd3) : 1'b1;
  assign mem_rdata  = mem[mem_addr[9:2]];
  assign din_valid  = din_en;
  assign din_data   = {16'hA5C3, din_idx};
  assign dout_ready = dout_en && (stall_en ? (stall_cnt[1:0] != 2'd1) : 1'b1);

  always @(posedge clk) begin
    stall_cnt <= stall_cnt + 8'd1;
    if (mem_valid && mem_ready) req_cyc <= req_cyc;
    if (mem_valid) req_cyc <= req_cyc + 1;
    if (mem_valid && mem_ready && mem_we) begin
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
    end
    if (cnt_clr) begin
      din_idx <= '0; wr_cnt <= 0; dout_cnt <= 0; req_cyc <= 0;
    end else begin
      if (din_valid && din_ready) din_idx <= din_idx + 16'd1;
      if (mem_valid && mem_ready && mem_we) wr_cnt <= wr_cnt + 1;
      if (dout_valid && dout_ready) begin
        dout_cnt  <= dout_cnt + 1;
        dout_last <= dout_data;
        keep_last <= dout_keep;
      end
    end
  end

  // handshake-stability monitor for R12, sampled between edges
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_mem_wait && !(mem_valid && mem_addr == prev_mem_addr)) hs_viol <= hs_viol + 1;
      if (prev_dout_wait && !(dout_valid && dout_data == prev_dout_data)) hs_viol <= hs_viol + 1;
      prev_mem_wait  <= mem_valid && !mem_ready;
      prev_mem_addr  <= mem_addr;
      prev_dout_wait <= dout_valid && !dout_ready;
      prev_dout_data <= dout_data;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic clear_counts();
    @(negedge clk); cnt_clr = 1'b1;
    @(negedge clk); cnt_clr = 1'b0;
  endtask

  task automatic wait_irq(input int lim);
    for (int i = 0; i < lim && !irq; i++) @(negedge clk);
  endtask

  task automatic fill(input int lo, input int hi, input logic [31:0] v);
    for (int i = lo; i < hi; i += 4) mem[i[9:2]] = v;
  endtask

  // {direction, size field}
  localparam logic [16:0] VECS [7] = '{
    17'h1_0008, 17'h1_0006, 17'h1_0002, 17'h1_0101,
    17'h0_000C, 17'h0_0006, 17'h0_0003
  };

  initial begin
    logic [31:0] d;
    int c;
    fill(0, 1024, 32'h0);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R14 reset state
    rd(3'd0, d); chk("R14 cmd", d, 32'h0);
    rd(3'd2, d); chk("R14 status", d, 32'h0);
    rd(3'd4, d); chk("R14 ptr", d, 32'h0);
    chk("R14 irq", {31'b0, irq}, 32'h0);
    chk("R14 mem_valid", {31'b0, mem_valid}, 32'h0);

    // R1 command masking
    wr(3'd0, 32'hFF); rd(3'd0, d); chk("R1 cmd readback", d, 32'h09);
    wr(3'd0, 32'h00); rd(3'd0, d); chk("R1 cmd clear", d, 32'h00);
    // R2 status write semantics
    wr(3'd2, 32'h67); rd(3'd2, d); chk("R2 spare bits stored", d, 32'h60);
    wr(3'd0, 32'h01); wr(3'd2, 32'h00); rd(3'd2, d); chk("R2 active kept", d, 32'h01);
    wr(3'd0, 32'h00); rd(3'd2, d); chk("R2 active cleared by stop", d, 32'h00);
    // R3 pointer alignment
    wr(3'd4, 32'h1234_5677); rd(3'd4, d); chk("R3 ptr low bits", d, 32'h1234_5674);

    // R4 start without pending transfer
    mem[8'h40] = 32'h200; mem[8'h41] = 32'h8000_0004;
    wr(3'd4, 32'h100); clear_counts(); din_en = 1'b1;
    wr(3'd0, 32'h09);
    repeat (10) @(negedge clk);
    rd(3'd2, d); chk("R4 active set", d & 32'h1, 32'h1);
    chk("R4 no request while idle", req_cyc, 0);
    dev_pending = 1'b1; wait_irq(200); dev_pending = 1'b0; din_en = 1'b0;
    chk("R4 run after pending", wr_cnt, 1);
    wr(3'd2, 32'h00); rd(3'd2, d); chk("R2 irq kept by zero write", d, 32'h04);
    wr(3'd2, 32'h04); rd(3'd2, d); chk("R2 irq cleared by one", d, 32'h00);

    // vector table: R6 R7 R8
    stall_en = 1'b1;
    for (int v = 0; v < 7; v++) begin
      logic dir; int L, beats, k;
      dir = VECS[v][16];
      L = int'(VECS[v][15:0] & 16'hFFFE);
      if (L == 0) L = 65536;
      beats = (L + 3) / 4;
      k = beats - 1;
      fill(12'h200, 12'h400, 32'h0);
      if (!dir) for (int i = 0; i < 64; i++) mem[8'h80 + i] = 32'hC0DE_0000 + i;
      mem[8'h40] = 32'h200; mem[8'h41] = 32'h8000_0000 | 32'(VECS[v][15:0]);
      wr(3'd2, 32'h04); wr(3'd4, 32'h100); clear_counts();
      din_en = dir; dout_en = !dir;
      wr(3'd0, dir ? 32'h09 : 32'h01);
      dev_pending = 1'b1;
      wait_irq(2000);
      dev_pending = 1'b0; din_en = 1'b0; dout_en = 1'b0;
      chk("R8 irq at end", {31'b0, irq}, 32'h1);
      rd(3'd2, d); chk("R8 active cleared", d & 32'h1, 32'h0);
      if (dir) begin
        chk("R7 write beats", wr_cnt, beats);
        chk("R6 last word lanes", mem[8'h80 + k],
            (L % 4 == 2) ? {16'h0, 16'(k)} : {16'hA5C3, 16'(k)});
        chk("R6 past end untouched", mem[8'h80 + beats], 32'h0);
      end else begin
        chk("R7 stream beats", dout_cnt, beats);
        chk("R7 last stream word", dout_last, 32'hC0DE_0000 + k);
        chk("R6 last keep", {28'b0, keep_last}, (L % 4 == 2) ? 32'h3 : 32'hF);
      end
    end

    // R5 two-descriptor chain with address advance
    fill(12'h300, 12'h360, 32'h0);
    mem[8'h60] = 32'h300; mem[8'h61] = 32'h4;
    mem[8'h62] = 32'h340; mem[8'h63] = 32'h8000_0006;
    wr(3'd2, 32'h04); wr(3'd4, 32'h180); clear_counts();
    din_en = 1'b1; wr(3'd0, 32'h09); dev_pending = 1'b1;
    wait_irq(500); dev_pending = 1'b0; din_en = 1'b0;
    chk("R5 writes", wr_cnt, 3);
    chk("R5 first buffer", mem[8'hC0], 32'hA5C3_0000);
    chk("R5 first untouched", mem[8'hC1], 32'h0);
    chk("R5 second buffer", mem[8'hD0], 32'hA5C3_0001);
    chk("R5 second advance", mem[8'hD1], 32'h0000_0002);

    // R13 / R9: device done and irq clear in the same cycle
    stall_en = 1'b0;
    mem[8'h40] = 32'h200; mem[8'h41] = 32'h8000_0040;
    wr(3'd2, 32'h04); wr(3'd4, 32'h100); clear_counts();
    wr(3'd0, 32'h09); dev_pending = 1'b1;
    repeat (20) @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'd2; reg_wdata = 32'h04; dev_done = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; dev_done = 1'b0; dev_pending = 1'b0;
    chk("R13 irq wins", {31'b0, irq}, 32'h1);
    rd(3'd2, d); chk("R9 active cleared", d & 32'h1, 32'h0);
    chk("R9 no beats", wr_cnt, 0);

    // R11 stop mid-run
    mem[8'h41] = 32'h8000_0000;
    wr(3'd2, 32'h04); clear_counts(); dout_en = 1'b1;
    wr(3'd0, 32'h01); dev_pending = 1'b1;
    repeat (40) @(negedge clk);
    wr(3'd0, 32'h00);
    rd(3'd2, d); chk("R4 stop clears active", d & 32'h1, 32'h0);
    repeat (10) @(negedge clk);
    c = dout_cnt;
    repeat (30) @(negedge clk);
    chk("R11 stream stopped", dout_cnt, c);
    chk("R11 no request", {31'b0, mem_valid}, 32'h0);
    chk("R11 irq unchanged", {31'b0, irq}, 32'h0);
    dev_pending = 1'b0; dout_en = 1'b0;

    // R6 zero count means 65536 bytes
    mem[8'h40] = 32'h200; mem[8'h41] = 32'h8000_0000;
    wr(3'd4, 32'h100); clear_counts(); dout_en = 1'b1;
    wr(3'd0, 32'h01); dev_pending = 1'b1;
    wait_irq(80000); dev_pending = 1'b0; dout_en = 1'b0;
    chk("R6 zero count beats", dout_cnt, 16384);

    // R10 descriptor cap: table without end flag
    for (int i = 0; i < 256; i++) mem[i] = (i % 2 == 0) ? 32'h0 : 32'h2;
    wr(3'd2, 32'h04); wr(3'd4, 32'h0); clear_counts(); dout_en = 1'b1;
    wr(3'd0, 32'h01); dev_pending = 1'b1;
    wait_irq(20000); dev_pending = 1'b0; dout_en = 1'b0;
    chk("R10 irq after cap", {31'b0, irq}, 32'h1);
    chk("R10 descriptors processed", dout_cnt, 512);

    chk("R12 handshake violations", hs_viol, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(190000 * 5);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule